// File: doc/BRIEF.md
# Multi-Channel Store-and-Forward Packet FIFO

This block buffers a stream of tagged beats for several logical channels inside one shared RAM. Each channel gets its own segment of `2**ADDR_W` words. Beats arrive on a valid/ready sink that carries data, a channel number, packet delimiters and an error field. They leave on a matching source, and only the channel named on the request input can drain. If the request input is configured away, channel 0 is the only channel that drains.

In packet-buffer mode (`PKT_BUF=1`) a channel offers nothing at its output until at least one whole packet, up to and including its last beat, sits in its segment. With `DROP_ERR=1` in that mode, a packet is erased before any of it reaches the output if any of its beats carries a nonzero error. The erase works by moving the segment's write pointer back to where the packet began. In streaming mode (`PKT_BUF=0`) a channel is offered once its stored word count reaches `SECT_AVAIL`.

A status port reports the fill level of the channel that `stat_chan` selects. It also reports up to two almost-full flags (fill at or above a level) and up to two almost-empty flags (fill at or below a level).

Top module: `mcpkt_fifo`

## Requirements
- R1: The beats of one channel leave in the order they were accepted. Data, sop, eop and error are unchanged. `out_chan` equals the channel being drained.
- R2: With `PKT_BUF=1`, `out_valid` stays 0 for the requested channel until the clock edge that accepts that channel's eop beat. From the next cycle on it is 1.
- R3: When a channel holds `2**ADDR_W` words, `in_ready` is 0 while `in_chan` names that channel. It is 1 for any channel that is not full, and such beats are accepted.
- R4: With `PKT_BUF=1` and `DROP_ERR=1`, a packet in which any beat has a nonzero `in_err` never reaches the output. This includes a single beat with sop=eop=1. After its eop edge the channel's fill equals its value before the packet, and the packets around it are delivered intact.
- R5: With `DROP_ERR=0`, a beat with a nonzero error is stored and leaves carrying the same error value.
- R6: With `PKT_BUF=0`, `out_valid` for the selected channel is 1 exactly when that channel holds at least `SECT_AVAIL` words.
- R7: `stat_fill` equals the number of words held by channel `stat_chan`. In packet mode this count includes beats of a packet that is not yet complete.
- R8: `stat_afull[k]` (k=0 uses `AF_LVL1`, k=1 uses `AF_LVL2`) is 1 exactly when k < `NUM_AF` and fill >= that level.
- R9: `stat_aempty[k]` (k=0 uses `AE_LVL1`, k=1 uses `AE_LVL2`) is 1 exactly when k < `NUM_AE` and fill <= that level.
- R10: With `USE_REQ=0`, `req_chan` is ignored, `out_chan` is always 0, and words held by other channels stay stored.
- R11: After reset every channel is empty, `out_valid` is 0, `in_ready` is 1, all almost-full flags are 0, and each enabled almost-empty flag is 1.
- R12: While `out_valid` is 1 and `out_ready` is 0, the offered beat stays valid and unchanged as long as the selected channel does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sink beat valid |
| in_ready | output | 1 | Sink can accept a beat for `in_chan` |
| in_data | input | DATA_W | Sink data |
| in_chan | input | CH_W | Channel of the sink beat |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_err | input | max(ERR_W,1) | Error field; ignored when ERR_W=0 |
| req_chan | input | CH_W | Channel to drain (used when USE_REQ=1) |
| out_valid | output | 1 | Source beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | DATA_W | Source data |
| out_chan | output | CH_W | Channel of the source beat |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_err | output | max(ERR_W,1) | Error field carried with the beat |
| stat_chan | input | CH_W | Channel whose level is reported |
| stat_fill | output | ADDR_W+1 | Words held by `stat_chan` |
| stat_afull | output | 2 | Almost-full flags |
| stat_aempty | output | 2 | Almost-empty flags |

## Verification
Packets are written to several channels with their beats interleaved and then drained channel by channel. This shows whether segments stay separate and whether order holds inside each one. An errored packet is placed between two clean packets, and a single-beat errored packet is sent as well. Together these show whether the rollback removes exactly the bad packet and leaves its neighbours intact. One segment is filled to the brim and then emptied word by word, with the level flags compared at every step. This pins each flag's edge to its exact level, and a second channel written while the first is full shows that backpressure applies per channel. A streaming-mode instance without a request input is fed across its section threshold in both directions. It also holds data on a channel that should never drain, and its errored beat shows that the error value is carried through.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

  // Flag vector for up to two thresholds; upper=1 tests fill>=level, else fill<=level.
  function automatic logic [1:0] thr_flags(input int unsigned fill,
                                           input int unsigned n_en,
                                           input int unsigned lvl_a,
                                           input int unsigned lvl_b,
                                           input bit upper);
    logic [1:0] f;
    for (int k = 0; k < 2; k++) begin
      int unsigned lvl;
      lvl  = (k == 0) ? lvl_a : lvl_b;
      f[k] = (k < int'(n_en)) && (upper ? (fill >= lvl) : (fill <= lvl));
    end
    return f;
  endfunction

  // Words held in a segment given wrapped pointers of one extra bit.
  function automatic longint unsigned seg_words(input longint unsigned wp,
                                                input longint unsigned rp,
                                                input int unsigned aw);
    longint unsigned mask;
    mask = (64'd1 << (aw + 1)) - 64'd1;
    return (wp - rp) & mask;
  endfunction

endpackage

// File: rtl/mcf_store.sv
module mcf_store #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int ADDR_W = 3,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rdata
);
  localparam int SEG   = 1 << ADDR_W;
  localparam int WORDS = NUM_CH * SEG;
  localparam int IDX_W = CH_W + ADDR_W;

  logic [WORD_W-1:0] mem [WORDS];
  logic [IDX_W-1:0]  widx, ridx;

  assign widx = {wr_ch, wr_addr};
  assign ridx = {rd_ch, rd_addr};

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/mcf_chan_ctrl.sv
module mcf_chan_ctrl #(
  parameter int ADDR_W     = 3,
  parameter int PKT_BUF    = 1,
  parameter int DROP_ERR   = 1,
  parameter int SECT_AVAIL = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic              wr_sop,
  input  logic              wr_eop,
  input  logic              wr_err,
  input  logic              rd_fire,
  input  logic              rd_eop,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W:0]   fill,
  output logic              full,
  output logic              avail,
  output logic              wr_keep
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1) << ADDR_W;
  localparam logic [PW-1:0] SECT  = PW'(SECT_AVAIL);

  logic [PW-1:0] wp, rp, sp, pkts;
  logic          err_seen;

  // Named events for the checks below.
  logic drop_now, commit_now, drain_eop;

  assign drop_now   = (PKT_BUF != 0) && (DROP_ERR != 0) && wr_fire && wr_eop &&
                      (wr_err || (err_seen && !wr_sop));
  assign commit_now = (PKT_BUF != 0) && wr_fire && wr_eop && !drop_now;
  assign drain_eop  = (PKT_BUF != 0) && rd_fire && rd_eop;
  assign wr_keep    = wr_fire && !drop_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      sp       <= '0;
      pkts     <= '0;
      err_seen <= 1'b0;
    end else begin
      if (drop_now)     wp <= wr_sop ? wp : sp;
      else if (wr_fire) wp <= wp + PW'(1);
      if (wr_fire && wr_sop) sp <= wp;
      if (wr_fire) err_seen <= !wr_eop && (wr_err || (err_seen && !wr_sop));
      if (rd_fire) rp <= rp + PW'(1);
      case ({commit_now, drain_eop})
        2'b10:   pkts <= pkts + PW'(1);
        2'b01:   pkts <= pkts - PW'(1);
        default: pkts <= pkts;
      endcase
    end
  end

  assign fill    = PW'(mcf_pkg::seg_words(longint'(wp), longint'(rp), ADDR_W));
  assign full    = (fill == DEPTH);
  assign avail   = (PKT_BUF != 0) ? (pkts != '0) : (fill >= SECT);
  assign wr_addr = wp[ADDR_W-1:0];
  assign rd_addr = rp[ADDR_W-1:0];

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    full |-> !wr_fire);

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
    fill <= DEPTH);

  generate
    if (PKT_BUF != 0) begin : g_pkt_chk
      assert_whole_pkt_R2: assert property (@(posedge clk) disable iff (rst)
        rd_fire |-> (pkts != '0));
      assert_drop_no_commit_R4: assert property (@(posedge clk) disable iff (rst)
        (drop_now && !drain_eop) |=> $stable(pkts));
    end else begin : g_sect_chk
      assert_section_R6: assert property (@(posedge clk) disable iff (rst)
        rd_fire |-> (fill >= SECT));
    end
  endgenerate
endmodule

// File: rtl/mcf_level_mon.sv
module mcf_level_mon #(
  parameter int ADDR_W  = 3,
  parameter int NUM_AF  = 2,
  parameter int NUM_AE  = 2,
  parameter int AF_LVL1 = 6,
  parameter int AF_LVL2 = 8,
  parameter int AE_LVL1 = 0,
  parameter int AE_LVL2 = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ADDR_W:0] fill,
  output logic [1:0]      afull,
  output logic [1:0]      aempty
);
  always_comb begin
    afull  = mcf_pkg::thr_flags(int'(fill), NUM_AF, AF_LVL1, AF_LVL2, 1'b1);
    aempty = mcf_pkg::thr_flags(int'(fill), NUM_AE, AE_LVL1, AE_LVL2, 1'b0);
  end

  assert_af_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(afull[0]) |-> (fill > $past(fill)));

  assert_ae_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(aempty[0]) |-> (fill < $past(fill)));
endmodule

// File: rtl/mcpkt_fifo.sv
module mcpkt_fifo #(
  parameter int NUM_CH     = 4,
  parameter int DATA_W     = 8,
  parameter int ERR_W      = 2,
  parameter int ADDR_W     = 3,
  parameter int PKT_BUF    = 1,
  parameter int DROP_ERR   = 1,
  parameter int SECT_AVAIL = 1,
  parameter int USE_REQ    = 1,
  parameter int NUM_AF     = 2,
  parameter int NUM_AE     = 2,
  parameter int AF_LVL1    = 6,
  parameter int AF_LVL2    = 8,
  parameter int AE_LVL1    = 0,
  parameter int AE_LVL2    = 2,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ERR_PW    = (ERR_W > 0) ? ERR_W : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CH_W-1:0]   in_chan,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [ERR_PW-1:0] in_err,
  input  logic [CH_W-1:0]   req_chan,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CH_W-1:0]   out_chan,
  output logic              out_sop,
  output logic              out_eop,
  output logic [ERR_PW-1:0] out_err,
  input  logic [CH_W-1:0]   stat_chan,
  output logic [ADDR_W:0]   stat_fill,
  output logic [1:0]        stat_afull,
  output logic [1:0]        stat_aempty
);
  localparam int WORD_W = DATA_W + 2 + ERR_PW;

  logic [ERR_PW-1:0] err_in;
  logic              err_any;
  logic [CH_W-1:0]   sel;

  logic [NUM_CH-1:0] wr_fire, rd_fire, full_v, avail_v, keep_v;
  logic [ADDR_W-1:0] wa_v [NUM_CH];
  logic [ADDR_W-1:0] ra_v [NUM_CH];
  logic [ADDR_W:0]   fill_v [NUM_CH];
  logic [1:0]        af_v [NUM_CH];
  logic [1:0]        ae_v [NUM_CH];

  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [WORD_W-1:0] wword, rword;
  logic              store_we;

  assign err_in  = (ERR_W > 0) ? in_err : '0;
  assign err_any = |err_in;
  assign sel     = (USE_REQ != 0) ? req_chan : '0;

  // Per-channel selection muxes.
  always_comb begin
    in_ready    = 1'b0;
    out_valid   = 1'b0;
    wr_addr     = '0;
    rd_addr     = '0;
    stat_fill   = '0;
    stat_afull  = '0;
    stat_aempty = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (in_chan == CH_W'(c)) begin
        in_ready = !full_v[c];
        wr_addr  = wa_v[c];
      end
      if (sel == CH_W'(c)) begin
        out_valid = avail_v[c];
        rd_addr   = ra_v[c];
      end
      if (stat_chan == CH_W'(c)) begin
        stat_fill   = fill_v[c];
        stat_afull  = af_v[c];
        stat_aempty = ae_v[c];
      end
    end
  end

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
      assign wr_fire[gc] = in_valid && in_ready && (in_chan == CH_W'(gc));
      assign rd_fire[gc] = out_valid && out_ready && (sel == CH_W'(gc));

      mcf_chan_ctrl #(
        .ADDR_W(ADDR_W), .PKT_BUF(PKT_BUF),
        .DROP_ERR(DROP_ERR), .SECT_AVAIL(SECT_AVAIL)
      ) u_ctrl (
        .clk(clk), .rst(rst),
        .wr_fire(wr_fire[gc]), .wr_sop(in_sop), .wr_eop(in_eop), .wr_err(err_any),
        .rd_fire(rd_fire[gc]), .rd_eop(out_eop),
        .wr_addr(wa_v[gc]), .rd_addr(ra_v[gc]), .fill(fill_v[gc]),
        .full(full_v[gc]), .avail(avail_v[gc]), .wr_keep(keep_v[gc])
      );

      mcf_level_mon #(
        .ADDR_W(ADDR_W), .NUM_AF(NUM_AF), .NUM_AE(NUM_AE),
        .AF_LVL1(AF_LVL1), .AF_LVL2(AF_LVL2), .AE_LVL1(AE_LVL1), .AE_LVL2(AE_LVL2)
      ) u_lvl (
        .clk(clk), .rst(rst), .fill(fill_v[gc]), .afull(af_v[gc]), .aempty(ae_v[gc])
      );
    end
  endgenerate

  assign store_we = |keep_v;
  assign wword    = {in_data, in_sop, in_eop, err_in};

  mcf_store #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) u_store (
    .clk(clk), .we(store_we), .wr_ch(in_chan), .wr_addr(wr_addr), .wdata(wword),
    .rd_ch(sel), .rd_addr(rd_addr), .rdata(rword)
  );

  assign out_data = rword[WORD_W-1 -: DATA_W];
  assign out_sop  = rword[ERR_PW+1];
  assign out_eop  = rword[ERR_PW];
  assign out_err  = rword[ERR_PW-1:0];
  assign out_chan = sel;

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      ((sel != $past(sel)) || (out_valid && (out_data == $past(out_data)))));

  assert_one_write_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_fire));
endmodule

// File: tb/mcpkt_fifo_bench.sv
module mcpkt_fifo_bench;
  localparam int CLK_P = 10;
  localparam int NCH = 4, DW = 8, EW = 2, AW = 3, CW = 2;
  localparam int BW = DW + 2 + EW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Instance A: packet-buffer mode with drop.
  logic a_in_valid = 0, a_in_ready, a_in_sop = 0, a_in_eop = 0;
  logic [DW-1:0] a_in_data = '0;
  logic [CW-1:0] a_in_chan = '0, a_req = '0, a_stat_chan = '0;
  logic [EW-1:0] a_in_err = '0;
  logic a_out_valid, a_out_ready = 0, a_out_sop, a_out_eop;
  logic [DW-1:0] a_out_data;
  logic [CW-1:0] a_out_chan;
  logic [EW-1:0] a_out_err;
  logic [AW:0]   a_fill;
  logic [1:0]    a_af, a_ae;

  mcpkt_fifo u_mcpkt_fifo (
    .clk(clk), .rst(rst),
    .in_valid(a_in_valid), .in_ready(a_in_ready), .in_data(a_in_data), .in_chan(a_in_chan),
    .in_sop(a_in_sop), .in_eop(a_in_eop), .in_err(a_in_err), .req_chan(a_req),
    .out_valid(a_out_valid), .out_ready(a_out_ready), .out_data(a_out_data),
    .out_chan(a_out_chan), .out_sop(a_out_sop), .out_eop(a_out_eop), .out_err(a_out_err),
    .stat_chan(a_stat_chan), .stat_fill(a_fill), .stat_afull(a_af), .stat_aempty(a_ae)
  );

  // Instance B: streaming, no drop, no request, one threshold of each kind.
  logic b_in_valid = 0, b_in_ready, b_in_sop = 0, b_in_eop = 0;
  logic [DW-1:0] b_in_data = '0;
  logic [CW-1:0] b_in_chan = '0, b_req = 2'd2, b_stat_chan = '0;
  logic [EW-1:0] b_in_err = '0;
  logic b_out_valid, b_out_ready = 0, b_out_sop, b_out_eop;
  logic [DW-1:0] b_out_data;
  logic [CW-1:0] b_out_chan;
  logic [EW-1:0] b_out_err;
  logic [AW:0]   b_fill;
  logic [1:0]    b_af, b_ae;

  mcpkt_fifo #(
    .PKT_BUF(0), .DROP_ERR(0), .SECT_AVAIL(3), .USE_REQ(0),
    .NUM_AF(1), .NUM_AE(1), .AE_LVL1(1)
  ) u_mcpkt_fifo_stream (
    .clk(clk), .rst(rst),
    .in_valid(b_in_valid), .in_ready(b_in_ready), .in_data(b_in_data), .in_chan(b_in_chan),
    .in_sop(b_in_sop), .in_eop(b_in_eop), .in_err(b_in_err), .req_chan(b_req),
    .out_valid(b_out_valid), .out_ready(b_out_ready), .out_data(b_out_data),
    .out_chan(b_out_chan), .out_sop(b_out_sop), .out_eop(b_out_eop), .out_err(b_out_err),
    .stat_chan(b_stat_chan), .stat_fill(b_fill), .stat_afull(b_af), .stat_aempty(b_ae)
  );

  // Reference queues for instance A: committed beats and the packet in flight.
  logic [BW-1:0] mq   [NCH][$];
  logic [BW-1:0] pend [NCH][$];
  bit            perr [NCH];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic a_push(input int ch, input logic [DW-1:0] d, input logic s,
                        input logic e, input logic [EW-1:0] er);
    @(negedge clk);
    a_in_chan = CW'(ch); a_in_data = d; a_in_sop = s; a_in_eop = e; a_in_err = er;
    a_in_valid = 1'b1;
    @(posedge clk);
    #1 a_in_valid = 1'b0;
    pend[ch].push_back({d, s, e, er});
    if (er != 0) perr[ch] = 1'b1;
    if (e) begin
      if (!perr[ch])
        while (pend[ch].size() > 0) mq[ch].push_back(pend[ch].pop_front());
      pend[ch].delete();
      perr[ch] = 1'b0;
    end
  endtask

  task automatic a_pop(input int ch);
    logic [BW-1:0] ex;
    @(negedge clk);
    a_req = CW'(ch); a_out_ready = 1'b1;
    #1;
    ex = mq[ch].pop_front();
    chk("R1 out_valid", 32'(a_out_valid), 32'd1);
    chk("R1 out_chan", 32'(a_out_chan), 32'(ch));
    chk("R1 out_data", 32'(a_out_data), 32'(ex[BW-1 -: DW]));
    chk("R1 out_sop", 32'(a_out_sop), 32'(ex[EW+1]));
    chk("R1 out_eop", 32'(a_out_eop), 32'(ex[EW]));
    chk("R1 out_err", 32'(a_out_err), 32'(ex[EW-1:0]));
    @(posedge clk);
    #1 a_out_ready = 1'b0;
  endtask

  task automatic a_stat(input int ch, input int f);
    @(negedge clk);
    a_stat_chan = CW'(ch);
    #1;
    chk("R7 fill", 32'(a_fill), 32'(f));
    chk("R8 afull", 32'(a_af), 32'({f >= 8, f >= 6}));
    chk("R9 aempty", 32'(a_ae), 32'({f <= 2, f <= 0}));
  endtask

  task automatic a_valid_is(input int ch, input logic exp, input string tag);
    @(negedge clk);
    a_req = CW'(ch);
    #1 chk(tag, 32'(a_out_valid), 32'(exp));
  endtask

  task automatic b_push(input int ch, input logic [DW-1:0] d, input logic s,
                        input logic e, input logic [EW-1:0] er);
    @(negedge clk);
    b_in_chan = CW'(ch); b_in_data = d; b_in_sop = s; b_in_eop = e; b_in_err = er;
    b_in_valid = 1'b1;
    @(posedge clk);
    #1 b_in_valid = 1'b0;
  endtask

  task automatic b_pop(input logic [DW-1:0] d, input logic [EW-1:0] er);
    @(negedge clk);
    b_out_ready = 1'b1;
    #1;
    chk("R6 out_valid", 32'(b_out_valid), 32'd1);
    chk("R10 out_chan", 32'(b_out_chan), 32'd0);
    chk("R1 out_data", 32'(b_out_data), 32'(d));
    chk("R5 out_err", 32'(b_out_err), 32'(er));
    @(posedge clk);
    #1 b_out_ready = 1'b0;
  endtask

  task automatic b_valid_is(input logic exp, input string tag);
    @(negedge clk);
    #1 chk(tag, 32'(b_out_valid), 32'(exp));
  endtask

  task automatic b_stat(input int ch, input int f);
    @(negedge clk);
    b_stat_chan = CW'(ch);
    #1;
    chk("R7 fill", 32'(b_fill), 32'(f));
    chk("R8 afull", 32'(b_af), 32'({1'b0, f >= 6}));
    chk("R9 aempty", 32'(b_ae), 32'({1'b0, f <= 1}));
  endtask

  // ---- scenarios ----
  task automatic t_reset;
    @(negedge clk);
    a_req = '0;
    #1;
    chk("R11 out_valid", 32'(a_out_valid), 32'd0);
    chk("R11 in_ready", 32'(a_in_ready), 32'd1);
    chk("R11 b_out_valid", 32'(b_out_valid), 32'd0);
    for (int c = 0; c < NCH; c++) a_stat(c, 0);
    b_stat(0, 0);
  endtask

  task automatic t_store_forward;
    a_push(1, 8'h10, 1, 0, 0);
    a_push(1, 8'h11, 0, 0, 0);
    a_valid_is(1, 1'b0, "R2 partial packet held");
    a_stat(1, 2);
    a_push(1, 8'h12, 0, 1, 0);
    a_valid_is(1, 1'b1, "R2 complete packet offered");
    repeat (3) a_pop(1);
    a_valid_is(1, 1'b0, "R2 nothing after packet");
  endtask

  task automatic t_interleave;
    a_push(0, 8'hA0, 1, 0, 0);
    a_push(2, 8'hC0, 1, 0, 0);
    a_push(0, 8'hA1, 0, 1, 0);
    a_push(2, 8'hC1, 0, 0, 0);
    a_push(2, 8'hC2, 0, 1, 0);
    a_push(0, 8'hA2, 1, 1, 0);
    repeat (3) a_pop(2);
    repeat (3) a_pop(0);
  endtask

  task automatic t_drop;
    a_push(3, 8'h31, 1, 0, 0);
    a_push(3, 8'h32, 0, 1, 0);
    a_push(3, 8'h33, 1, 0, 0);
    a_push(3, 8'h34, 0, 0, 2);
    a_push(3, 8'h35, 0, 1, 0);
    @(negedge clk); a_stat_chan = 2'd3;
    #1 chk("R4 fill restored", 32'(a_fill), 32'd2);
    a_push(3, 8'h36, 1, 1, 1);
    @(negedge clk);
    #1 chk("R4 single-beat drop", 32'(a_fill), 32'd2);
    a_push(3, 8'h37, 1, 1, 0);
    repeat (3) a_pop(3);
    a_valid_is(3, 1'b0, "R4 dropped beats absent");
  endtask

  task automatic t_full;
    for (int i = 0; i < 8; i++) begin
      a_push(1, 8'(8'h40 + i), (i == 0), (i == 7), 0);
      a_stat(1, i + 1);
    end
    @(negedge clk);
    a_in_chan = 2'd1;
    #1 chk("R3 full channel not ready", 32'(a_in_ready), 32'd0);
    a_in_chan = 2'd2;
    #1 chk("R3 other channel ready", 32'(a_in_ready), 32'd1);
    a_push(2, 8'h55, 1, 1, 0);
    a_stat(2, 1);
    for (int i = 0; i < 8; i++) begin
      a_pop(1);
      a_stat(1, 7 - i);
    end
    a_pop(2);
  endtask

  task automatic t_hold;
    a_push(0, 8'h77, 1, 1, 0);
    @(negedge clk);
    a_req = 2'd0; a_out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk("R12 held valid", 32'(a_out_valid), 32'd1);
      chk("R12 held data", 32'(a_out_data), 32'h77);
    end
    a_pop(0);
  endtask

  task automatic t_stream;
    b_push(0, 8'h50, 1, 0, 3);
    b_valid_is(1'b0, "R6 below section (1)");
    b_push(0, 8'h51, 0, 0, 0);
    b_valid_is(1'b0, "R6 below section (2)");
    b_push(0, 8'h52, 0, 1, 0);
    b_valid_is(1'b1, "R6 at section (3)");
    b_pop(8'h50, 2'd3);
    b_valid_is(1'b0, "R6 dropped below section");
    b_stat(0, 2);
  endtask

  task automatic t_noreq;
    for (int i = 0; i < 8; i++) b_push(1, 8'(8'h60 + i), (i == 0), (i == 7), 0);
    b_valid_is(1'b0, "R10 other channel not drained");
    b_stat(1, 8);
    @(negedge clk);
    b_in_chan = 2'd1;
    #1 chk("R3 stream full channel", 32'(b_in_ready), 32'd0);
    b_push(0, 8'h53, 1, 1, 0);
    b_pop(8'h51, 2'd0);
    b_stat(1, 8);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) perr[c] = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_store_forward();
    t_interleave();
    t_drop();
    t_full();
    t_hold();
    t_stream();
    t_noreq();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule